// File: doc/BRIEF.md
# Performance Counter Bank with Memory-Mapped Access

This block keeps four event counters for a small in-order processor and lets the processor read and clear them through its memory-mapped I/O data port. One counter tracks elapsed clock cycles. One tracks retired instructions. One tracks resolved conditional branches. The last tracks branches whose predicted direction matched the resolved one. The pipeline raises single-cycle event pulses, and the bank adds them up.

Software reads a counter with a word load from that counter's fixed address. The response comes back one cycle after the request is accepted, the same latency as a synchronous data memory. A word store to one dedicated address clears every counter at once, and the stored data plays no part. The request side is a valid/ready channel. The response side is valid/ready with a one-entry output register. A request is accepted on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low only while a load response is held, that is while `rsp_valid` is high and `rsp_ready` is low. A held response keeps its data stable until it is taken. Stores never produce a response.

Top module: `perf_counter_unit`

## Requirements
- R1: While `rst_n` is low, `rsp_valid` is low and all four counters are zero. A read accepted in the first cycle after reset returns zero for every counter.
- R2: The cycle counter increases by one on every clock edge where `rst_n` is high and no clear store is accepted.
- R3: The retired-instruction counter increases by one on each edge where `ev_retire` is high.
- R4: The branch counter increases by one on each edge where `ev_branch` is high.
- R5: The correct-prediction counter increases only on edges where `ev_branch` and `ev_pred_ok` are both high. `ev_pred_ok` alone has no effect.
- R6: An accepted load returns a counter one cycle later. The address map is: 0x8000_0010 selects cycles, 0x8000_0014 selects retired instructions, 0x8000_001C selects branches, and 0x8000_0020 selects correct predictions. The returned value is the count before the update made on the accepting edge.
- R7: An accepted load from any other address returns zero. This includes 0x8000_0018 and every address with bit 31 clear.
- R8: An accepted store to 0x8000_0018 sets every counter to zero on that edge, whatever its data and whatever events arrive in the same cycle. A store to any other address changes no counter. Stores return no response.
- R9: `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high and `rsp_data` stays stable.
- R10: Counters wrap modulo 2^`CNT_W`. Read data is the counter zero-extended to `DATA_W` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_retire | input | 1 | One instruction retired this cycle |
| ev_branch | input | 1 | One conditional branch resolved this cycle |
| ev_pred_ok | input | 1 | Prediction of the resolving branch was correct |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data (not used by any mapped location) |
| rsp_valid | output | 1 | Load response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | DATA_W | Load response data |

## Verification
The assertions check these rules on every cycle:
- A counter advances or holds in step with its increment and clear inputs, and wraps to zero.
- Decode never selects two counters at once.
- A held response stays frozen, and `req_ready` stays low while it is held.
- An accepted load always produces a response on the next edge.

The scenarios are needed for the parts that depend on history:
- Whether each address returns the right count from the right cycle.
- That a clear wins over same-cycle events and ignores its data.
- That stores elsewhere and bare prediction pulses leave the counts alone.
- That a narrow counter really wraps after a long run.

// File: rtl/perf_counter_pkg.sv
package perf_counter_pkg;
  localparam int NUM_CNT = 4;
  localparam int IDX_W   = 2;

  typedef enum logic [IDX_W-1:0] {
    CNT_CYCLE  = 2'd0,
    CNT_RETIRE = 2'd1,
    CNT_BRANCH = 2'd2,
    CNT_PREDOK = 2'd3
  } cnt_idx_e;

  localparam logic [31:0] ADDR_CYCLE  = 32'h8000_0010;
  localparam logic [31:0] ADDR_RETIRE = 32'h8000_0014;
  localparam logic [31:0] ADDR_CLEAR  = 32'h8000_0018;
  localparam logic [31:0] ADDR_BRANCH = 32'h8000_001C;
  localparam logic [31:0] ADDR_PREDOK = 32'h8000_0020;

  function automatic logic [31:0] addr_of(input int idx);
    case (idx)
      0:       return ADDR_CYCLE;
      1:       return ADDR_RETIRE;
      2:       return ADDR_BRANCH;
      default: return ADDR_PREDOK;
    endcase
  endfunction
endpackage

// File: rtl/perf_counter_cell.sv
module perf_counter_cell #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) q <= '0;
    else if (inc)      q <= q + ONE;
  end

  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));
  p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(q));
  p_wrap_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && inc && (&q)) |=> (q == '0));
  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && inc && !(&q)) |=> (q == $past(q) + ONE));
endmodule

// File: rtl/perf_counter_decode.sv
module perf_counter_decode
  import perf_counter_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_CNT-1:0] rd_sel,
  output logic               clr_hit
);
  for (genvar g = 0; g < NUM_CNT; g++) begin : g_sel
    assign rd_sel[g] = (addr == ADDR_W'(addr_of(g)));
  end
  assign clr_hit = (addr == ADDR_W'(ADDR_CLEAR));

  always_comb begin
    p_sel_onehot_r6: assert ($onehot0({rd_sel, clr_hit}));
  end
endmodule

// File: rtl/perf_counter_resp.sv
module perf_counter_resp #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_data  <= load_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  p_rsp_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> rsp_valid);
endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit
  import perf_counter_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_retire,
  input  logic              ev_branch,
  input  logic              ev_pred_ok,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data
);
  logic               accept;
  logic               do_load;
  logic               do_clear;
  logic [NUM_CNT-1:0] rd_sel;
  logic               clr_hit;
  logic [NUM_CNT-1:0] inc_vec;
  logic [CNT_W-1:0]   cnt_q [NUM_CNT];
  logic [DATA_W-1:0]  rd_data;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign do_load   = accept && !req_write;
  assign do_clear  = accept && req_write && clr_hit;

  assign inc_vec[CNT_CYCLE]  = 1'b1;
  assign inc_vec[CNT_RETIRE] = ev_retire;
  assign inc_vec[CNT_BRANCH] = ev_branch;
  assign inc_vec[CNT_PREDOK] = ev_branch && ev_pred_ok;

  perf_counter_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr    (req_addr),
    .rd_sel  (rd_sel),
    .clr_hit (clr_hit)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    perf_counter_cell #(.CNT_W(CNT_W)) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (do_clear),
      .inc   (inc_vec[g]),
      .q     (cnt_q[g])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (rd_sel[i]) rd_data[CNT_W-1:0] = cnt_q[i];
    end
  end

  perf_counter_resp #(.DATA_W(DATA_W)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (do_load),
    .load_data (rd_data),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  p_stall_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
  p_pred_needs_branch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_branch && !do_clear) |=> $stable(cnt_q[CNT_PREDOK]));
  p_clear_any_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (do_clear && (req_wdata != '0)) |=> (cnt_q[CNT_CYCLE] == '0));
  p_store_no_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write && !rsp_valid) |=> !rsp_valid);
endmodule

// File: tb/tb_perf_counter_unit.sv
module tb_perf_counter_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n, ev_retire, ev_branch, ev_pred_ok;
  logic        req_valid, req_write, rsp_ready;
  logic [31:0] req_addr, req_wdata;
  logic        req_ready, rsp_valid, req_ready_w, rsp_valid_w;
  logic [31:0] rsp_data, rsp_data_w;

  perf_counter_unit dut (
    .clk(clk), .rst_n(rst_n), .ev_retire(ev_retire), .ev_branch(ev_branch),
    .ev_pred_ok(ev_pred_ok), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data));

  perf_counter_unit #(.CNT_W(8)) dut_w (
    .clk(clk), .rst_n(rst_n), .ev_retire(ev_retire), .ev_branch(ev_branch),
    .ev_pred_ok(ev_pred_ok), .req_valid(req_valid), .req_ready(req_ready_w),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid_w), .rsp_ready(rsp_ready), .rsp_data(rsp_data_w));

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  int unsigned mc [4];
  bit          mv;
  logic [31:0] md;
  string       mtag;

  function automatic logic [31:0] exp_read(input logic [31:0] a);
    case (a)
      32'h8000_0010: return mc[0];
      32'h8000_0014: return mc[1];
      32'h8000_001C: return mc[2];
      32'h8000_0020: return mc[3];
      default:       return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [31:0] a);
    case (a)
      32'h8000_0010: return "R2";
      32'h8000_0014: return "R3";
      32'h8000_001C: return "R4";
      32'h8000_0020: return "R5";
      default:       return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    bit acc;
    bit nv;
    logic [31:0] nd;
    string nt;
    #1;
    check("R9", {31'b0, req_ready},   {31'b0, (!mv || rsp_ready)});
    check("R9", {31'b0, req_ready_w}, {31'b0, (!mv || rsp_ready)});
    acc = req_valid && (!mv || rsp_ready);
    nv = mv; nd = md; nt = mtag;
    if (acc && !req_write) begin
      nv = 1'b1; nd = exp_read(req_addr); nt = tag_of(req_addr);
    end else if (rsp_ready) begin
      nv = 1'b0;
    end
    @(posedge clk);
    if (acc && req_write && req_addr == 32'h8000_0018) begin
      for (int i = 0; i < 4; i++) mc[i] = 0;
    end else begin
      mc[0]++;
      if (ev_retire) mc[1]++;
      if (ev_branch) mc[2]++;
      if (ev_branch && ev_pred_ok) mc[3]++;
    end
    mv = nv; md = nd; mtag = nt;
    @(negedge clk);
    check("R6", {31'b0, rsp_valid},   {31'b0, mv});
    check("R6", {31'b0, rsp_valid_w}, {31'b0, mv});
    if (mv) begin
      check(mtag,  rsp_data,   md);
      check("R10", rsp_data_w, md & 32'hFF);
    end
  endtask

  task automatic drive(input bit v, input bit w, input logic [31:0] a, input logic [31:0] d,
                       input bit ret, input bit br, input bit ok, input bit rdy);
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    ev_retire = ret; ev_branch = br; ev_pred_ok = ok; rsp_ready = rdy;
    step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 32'h0, 32'h0, 0, 0, 0, 1);
  endtask

  task automatic rd(input logic [31:0] a);
    drive(1, 0, a, 32'h0, 0, 0, 0, 1);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] addrs [7];
    void'($urandom(32'd20240611));
    addrs[0] = 32'h8000_0010; addrs[1] = 32'h8000_0014; addrs[2] = 32'h8000_001C;
    addrs[3] = 32'h8000_0020; addrs[4] = 32'h8000_0024; addrs[5] = 32'h0000_0010;
    addrs[6] = 32'h8000_0018;
    rst_n = 1'b0; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    ev_retire = 0; ev_branch = 0; ev_pred_ok = 0; rsp_ready = 1;
    for (int i = 0; i < 4; i++) mc[i] = 0;
    mv = 0; md = 0; mtag = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", {31'b0, rsp_valid}, 32'h0);
    check("R1", {31'b0, req_ready}, 32'h1);
    rst_n = 1'b1;
    // R1: first reads after reset see zero event counts
    mtag = "R1";
    drive(1, 0, 32'h8000_0014, 0, 0, 0, 0, 1);
    drive(1, 0, 32'h8000_0020, 0, 0, 0, 0, 1);
    // R3 R4 R5: directed event patterns
    for (int i = 0; i < 6; i++) drive(0, 0, 0, 0, i % 2, 1, i < 4, 1);
    rd(32'h8000_0010); rd(32'h8000_0014); rd(32'h8000_001C); rd(32'h8000_0020);
    // R5: prediction flag without a branch is ignored
    for (int i = 0; i < 5; i++) drive(0, 0, 0, 0, 0, 0, 1, 1);
    rd(32'h8000_0020);
    // R8: clear with busy events and nonzero data
    drive(1, 1, 32'h8000_0018, 32'hDEAD_BEEF, 1, 1, 1, 1);
    rd(32'h8000_0010); rd(32'h8000_0014); rd(32'h8000_001C); rd(32'h8000_0020);
    // R8: store to a counter address changes nothing
    drive(1, 1, 32'h8000_0014, 32'h0, 1, 0, 0, 1);
    rd(32'h8000_0014);
    // R7: unmapped and clear-address reads
    rd(32'h8000_0024); rd(32'h0000_0010); rd(32'h8000_0018);
    // R9: back-pressure hold
    drive(1, 0, 32'h8000_0010, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) drive(1, 0, 32'h8000_0014, 0, 1, 0, 0, 0);
    drive(1, 0, 32'h8000_0014, 0, 0, 0, 0, 1);
    idle(1);
    // R10: narrow counter wraps past 255 cycles
    idle(300);
    rd(32'h8000_0010);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      bit v, w, r, b, o, rdy;
      logic [31:0] a;
      v = ($urandom % 2) == 0;
      w = ($urandom % 8) == 0;
      a = addrs[$urandom % 7];
      if (w && a == 32'h8000_0018 && ($urandom % 8) != 0) a = 32'h8000_0014;
      r = $urandom % 2; b = $urandom % 2; o = ($urandom % 4) != 0;
      rdy = ($urandom % 4) != 0;
      drive(v, w, a, $urandom, r, b, o, rdy);
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule